// File: doc/BRIEF.md
# Interrupt Router with Retention Blocking

This block takes every device interrupt line of the chip before any other interrupt logic sees it. It passes each line to the management coprocessor, and it also forwards each line to the CPU interrupt controller on one of two outputs, fast or normal. Software can force any line high through a set latch and drop that latch through a clear write. Per-line register bits choose the CPU-side output type and mark a line as a wake source.

During core retention the coprocessor sets a single block bit. That bit holds every CPU-side output low. The coprocessor view and the wake logic keep running. Any wake-enabled interrupt that is active raises a registered wake request, which brings the cores back. Once software clears the block bit, pending lines reach the CPU controller in the same cycle.

Registers sit behind a plain synchronous bus. The address is `{group[2:0], bank}` and each bank covers `DATA_W` lines. Reads return data one cycle after the address is presented.

Top module: `irq_router`

## Requirements
- R1: After reset the latches, type bits, wake enables and block bit are all 0. `cpu_irq`, `cpu_fiq` and `wake_req` are low, and the bus reads 0.
- R2: For every line i, `cop_irq[i]` is `dev_irq[i]` OR the software latch of line i. The type bits and the block bit have no effect on it.
- R3: A write to group 0 (set) in bank b sets the latch of line b*DATA_W+k for every 1 in data bit k. Data bits that are 0 leave their latches unchanged.
- R4: A write to group 1 (clear) resets the latch of each line whose data bit is 1. Other latches are unchanged, and a line whose hardware input is high stays high on `cop_irq`.
- R5: Group 2 holds the type bits. A 1 sends an active line to `cpu_fiq`, a 0 sends it to `cpu_irq`, and no line is ever on both outputs.
- R6: The block bit is group 4, bank 0, bit 0. While it is 1, `cpu_irq` and `cpu_fiq` are all zero.
- R7: Group 3 holds the wake enables. In the cycle after any line has `cop_irq` AND its wake enable high, `wake_req` is 1, and 0 otherwise, whatever the block bit.
- R8: While the block bit is 0, the OR of `cpu_irq` and `cpu_fiq` equals `cop_irq`. Interrupts left pending during a block appear right after the write that clears the bit.
- R9: A read returns the addressed bank one cycle later. Group 0 returns the latches, group 1 the effective lines (`cop_irq`), group 2 the types, group 3 the wake enables, and group 4 the block bit in bit 0.
- R10: Writes to group codes 5 to 7 change nothing. Data bits for line numbers at or above N_LINES read as 0 and cannot be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | N_LINES | Device interrupt lines, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3+BANK_W | Group code in the upper 3 bits, bank index below |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| cop_irq | output | N_LINES | Effective interrupts to the coprocessor |
| cpu_irq | output | N_LINES | Normal-type interrupts to the CPU controller |
| cpu_fiq | output | N_LINES | Fast-type interrupts to the CPU controller |
| wake_req | output | 1 | Registered wake request |

## Verification
The bench clears the block bit while software-set lines are pending and checks that they appear at once. A design that latched the gated value would lose them. It drives a hardware line high and then clear-writes its latch, which catches a router that lets the clear mask the input rather than reset the latch. It sets the block bit with wake-enabled lines active, which exposes a wake path wrongly gated by the block bit or taken from the wrong cycle. It also writes the unused group codes and the bits above the last line, which catches decoders that alias groups or keep phantom latches.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int GRP_W = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_SET   = 3'd0,
    GRP_CLR   = 3'd1,
    GRP_TYPE  = 3'd2,
    GRP_WAKE  = 3'd3,
    GRP_BLOCK = 3'd4
  } grp_e;

  // effective level of one line
  function automatic logic line_level(input logic hw, input logic sw);
    return hw | sw;
  endfunction

  // CPU-side fast output for one line
  function automatic logic to_fast(input logic lvl, input logic fast, input logic blk);
    return lvl & fast & ~blk;
  endfunction

  // CPU-side normal output for one line
  function automatic logic to_normal(input logic lvl, input logic fast, input logic blk);
    return lvl & ~fast & ~blk;
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int N_LINES = 48,
  parameter int DATA_W  = 32,
  parameter int NBANK   = 2,
  parameter int BANK_W  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [GRP_W+BANK_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [N_LINES-1:0]       eff_i,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [N_LINES-1:0]       latch_o,
  output logic [N_LINES-1:0]       type_o,
  output logic [N_LINES-1:0]       wen_o,
  output logic                     blk_o
);
  localparam int PADW = NBANK * DATA_W;

  logic [GRP_W-1:0]  grp;
  logic [BANK_W-1:0] bank;
  assign grp  = bus_addr[GRP_W+BANK_W-1:BANK_W];
  assign bank = bus_addr[BANK_W-1:0];

  logic [N_LINES-1:0] latch_q, type_q, wen_q;
  logic               blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      type_q  <= '0;
      wen_q   <= '0;
      blk_q   <= 1'b0;
    end else if (bus_wr) begin
      for (int i = 0; i < N_LINES; i++) begin
        if (bank == BANK_W'(i / DATA_W)) begin
          case (grp)
            GRP_SET:  if (bus_wdata[i % DATA_W]) latch_q[i] <= 1'b1;
            GRP_CLR:  if (bus_wdata[i % DATA_W]) latch_q[i] <= 1'b0;
            GRP_TYPE: type_q[i] <= bus_wdata[i % DATA_W];
            GRP_WAKE: wen_q[i]  <= bus_wdata[i % DATA_W];
            default: ;
          endcase
        end
      end
      if (grp == GRP_BLOCK && bank == '0) blk_q <= bus_wdata[0];
    end
  end

  logic [PADW-1:0]   pad_latch, pad_eff, pad_type, pad_wen;
  logic [DATA_W-1:0] rd_mux;

  assign pad_latch = PADW'(latch_q);
  assign pad_eff   = PADW'(eff_i);
  assign pad_type  = PADW'(type_q);
  assign pad_wen   = PADW'(wen_q);

  always_comb begin
    rd_mux = '0;
    if (32'(bank) < NBANK) begin
      case (grp)
        GRP_SET:   rd_mux = pad_latch[32'(bank)*DATA_W +: DATA_W];
        GRP_CLR:   rd_mux = pad_eff[32'(bank)*DATA_W +: DATA_W];
        GRP_TYPE:  rd_mux = pad_type[32'(bank)*DATA_W +: DATA_W];
        GRP_WAKE:  rd_mux = pad_wen[32'(bank)*DATA_W +: DATA_W];
        GRP_BLOCK: rd_mux = (bank == '0) ? DATA_W'(blk_q) : '0;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  assign latch_o = latch_q;
  assign type_o  = type_q;
  assign wen_o   = wen_q;
  assign blk_o   = blk_q;
endmodule

// File: rtl/irq_router_fwd.sv
module irq_router_fwd
  import irq_router_pkg::*;
#(
  parameter int N_LINES = 48
) (
  input  logic [N_LINES-1:0] dev_irq,
  input  logic [N_LINES-1:0] latch_i,
  input  logic [N_LINES-1:0] type_i,
  input  logic               blk_i,
  output logic [N_LINES-1:0] eff_o,
  output logic [N_LINES-1:0] cpu_irq,
  output logic [N_LINES-1:0] cpu_fiq
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign eff_o[i]   = line_level(dev_irq[i], latch_i[i]);
    assign cpu_irq[i] = to_normal(eff_o[i], type_i[i], blk_i);
    assign cpu_fiq[i] = to_fast(eff_o[i], type_i[i], blk_i);
  end
endmodule

// File: rtl/irq_router_wake.sv
module irq_router_wake #(
  parameter int N_LINES = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] eff_i,
  input  logic [N_LINES-1:0] wen_i,
  output logic               any_wake_o,
  output logic               wake_req
);
  assign any_wake_o = |(eff_i & wen_i);

  always_ff @(posedge clk) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= any_wake_o;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter  int N_LINES = 48,
  parameter  int DATA_W  = 32,
  localparam int NBANK   = (N_LINES + DATA_W - 1) / DATA_W,
  localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W  = GRP_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] dev_irq,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [N_LINES-1:0] cop_irq,
  output logic [N_LINES-1:0] cpu_irq,
  output logic [N_LINES-1:0] cpu_fiq,
  output logic               wake_req
);
  logic [N_LINES-1:0] latch_w, type_w, wen_w, eff_w;
  logic               blk_w;
  logic               any_wake_w;

  irq_router_regs #(
    .N_LINES(N_LINES), .DATA_W(DATA_W), .NBANK(NBANK), .BANK_W(BANK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .eff_i(eff_w), .bus_rdata(bus_rdata),
    .latch_o(latch_w), .type_o(type_w), .wen_o(wen_w), .blk_o(blk_w)
  );

  irq_router_fwd #(.N_LINES(N_LINES)) u_fwd (
    .dev_irq(dev_irq), .latch_i(latch_w), .type_i(type_w), .blk_i(blk_w),
    .eff_o(eff_w), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq)
  );

  irq_router_wake #(.N_LINES(N_LINES)) u_wake (
    .clk(clk), .rst_n(rst_n), .eff_i(eff_w), .wen_i(wen_w),
    .any_wake_o(any_wake_w), .wake_req(wake_req)
  );

  assign cop_irq = eff_w;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_LINES = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] dev_irq,
  input logic [N_LINES-1:0] cop_irq,
  input logic [N_LINES-1:0] cpu_irq,
  input logic [N_LINES-1:0] cpu_fiq,
  input logic               wake_req,
  input logic               blk_w,
  input logic [N_LINES-1:0] wen_w
);
  a_r2_dev_reaches_cop: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq & ~cop_irq) == '0);

  a_r5_one_output_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq & cpu_fiq) == '0);

  a_r6_block_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    blk_w |-> (cpu_irq == '0 && cpu_fiq == '0));

  a_r7_wake_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cop_irq & wen_w)) |=> wake_req);

  a_r7_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cop_irq & wen_w)) |=> !wake_req);

  a_r8_unblocked_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_w |-> ((cpu_irq | cpu_fiq) == cop_irq));
endmodule

bind irq_router irq_router_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cop_irq(cop_irq),
  .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .wake_req(wake_req),
  .blk_w(blk_w), .wen_w(wen_w)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
  localparam int N  = 48;
  localparam int DW = 32;
  localparam int NV = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_irq = '0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  cop_irq, cpu_irq, cpu_fiq;
  logic          wake_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_router #(.N_LINES(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cop_irq(cop_irq), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .wake_req(wake_req)
  );

  // vector: dev, set, type, wake-enable, block
  typedef struct packed {
    logic [N-1:0] dev;
    logic [N-1:0] set;
    logic [N-1:0] typ;
    logic [N-1:0] wen;
    logic         blk;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{48'h0, 48'h0, 48'h0, 48'h0, 1'b0},
    '{48'h0000_0000_0001, 48'h0, 48'h0, 48'h0, 1'b0},
    '{48'h8000_0000_0000, 48'h0, 48'h8000_0000_0000, 48'h8000_0000_0000, 1'b0},
    '{48'h0, 48'h0001_0000_0010, 48'h0001_0000_0000, 48'h0000_0000_0010, 1'b0},
    '{48'h00F0_0000_0F00, 48'h0, 48'h00F0_0000_0000, 48'h0000_0000_0100, 1'b1},
    '{48'h0000_0000_0002, 48'h0, 48'h0, 48'h0000_0000_0001, 1'b1},
    '{48'h1234_0000_5678, 48'h0000_00FF_0000, 48'hAAAA_AAAA_AAAA, 48'h0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] grp, input logic bank, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = {grp, bank}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] grp, input logic bank, output logic [DW-1:0] d);
    bus_addr = {grp, bank};
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wr48(input logic [2:0] grp, input logic [N-1:0] v);
    bwrite(grp, 1'b0, v[31:0]);
    bwrite(grp, 1'b1, {16'h0, v[47:32]});
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd;
    logic [N-1:0]  ec, ei, ef;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cpu_irq", 64'(cpu_irq), 64'h0);
    check("R1 cpu_fiq", 64'(cpu_fiq), 64'h0);
    check("R1 wake_req", 64'(wake_req), 64'h0);
    check("R1 rdata", 64'(bus_rdata), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bread(3'd2, 1'b1, rd); check("R1 type bank1", 64'(rd), 64'h0);
    bread(3'd4, 1'b0, rd); check("R1 block", 64'(rd), 64'h0);

    // table walk: R2 R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      dev_irq = '0;
      wr48(3'd4, '0);
      wr48(3'd1, '1);
      wr48(3'd2, VECS[v].typ);
      wr48(3'd3, VECS[v].wen);
      wr48(3'd0, VECS[v].set);
      bwrite(3'd4, 1'b0, DW'(VECS[v].blk));
      dev_irq = VECS[v].dev;
      @(negedge clk);
      ec = VECS[v].dev | VECS[v].set;
      ei = VECS[v].blk ? '0 : (ec & ~VECS[v].typ);
      ef = VECS[v].blk ? '0 : (ec & VECS[v].typ);
      check($sformatf("R2 cop v%0d", v), 64'(cop_irq), 64'(ec));
      check($sformatf("R5/R6 irq v%0d", v), 64'(cpu_irq), 64'(ei));
      check($sformatf("R5/R6 fiq v%0d", v), 64'(cpu_fiq), 64'(ef));
      check($sformatf("R7 wake v%0d", v), 64'(wake_req), 64'(|(ec & VECS[v].wen)));
      bread(3'd0, 1'b1, rd);
      check($sformatf("R3 latch bank1 v%0d", v), 64'(rd), 64'(VECS[v].set[47:32]));
    end

    // R8: pending during block, released on clear
    dev_irq = '0;
    wr48(3'd1, '1);
    wr48(3'd2, 48'h0000_0000_0F00);
    wr48(3'd3, '0);
    bwrite(3'd4, 1'b0, 32'h1);
    wr48(3'd0, 48'h0002_0000_0F03);
    check("R6 blocked irq", 64'(cpu_irq), 64'h0);
    check("R6 blocked fiq", 64'(cpu_fiq), 64'h0);
    check("R7 no wake when not enabled", 64'(wake_req), 64'h0);
    bwrite(3'd4, 1'b0, 32'h0);
    check("R8 released irq", 64'(cpu_irq), 64'h0002_0000_0003);
    check("R8 released fiq", 64'(cpu_fiq), 64'h0000_0000_0F00);

    // R4: clear keeps hardware-high line and untouched latches
    wr48(3'd1, '1);
    wr48(3'd0, 48'h0000_0000_0021);
    dev_irq = 48'h0000_0000_0020;
    bwrite(3'd1, 1'b0, 32'h0000_0021);
    check("R4 hw line survives clear", 64'(cop_irq), 64'h0000_0000_0020);
    bread(3'd0, 1'b0, rd); check("R4 latches cleared", 64'(rd), 64'h0);
    wr48(3'd0, 48'h0000_0000_0003);
    bwrite(3'd1, 1'b0, 32'h0000_0001);
    dev_irq = '0;
    #1;
    check("R4 other latch kept", 64'(cop_irq), 64'h0000_0000_0002);

    // R9: readback of each group
    wr48(3'd2, 48'hBEEF_1234_5678);
    wr48(3'd3, 48'h00C0_0000_0001);
    dev_irq = 48'h0100_0000_0000;
    bread(3'd2, 1'b1, rd); check("R9 type bank1", 64'(rd), 64'h0000_BEEF);
    bread(3'd2, 1'b0, rd); check("R9 type bank0", 64'(rd), 64'h1234_5678);
    bread(3'd3, 1'b1, rd); check("R9 wake bank1", 64'(rd), 64'h0000_00C0);
    bread(3'd1, 1'b1, rd); check("R9 eff bank1", 64'(rd), 64'h0000_0100);
    bread(3'd1, 1'b0, rd); check("R9 eff bank0", 64'(rd), 64'h0000_0002);
    bwrite(3'd4, 1'b0, 32'hFFFF_FFFF);
    bread(3'd4, 1'b0, rd); check("R9 block readback", 64'(rd), 64'h1);
    bwrite(3'd4, 1'b0, 32'h0);

    // R10: unused groups and phantom bits
    dev_irq = '0;
    bwrite(3'd5, 1'b0, 32'hFFFF_FFFF);
    bwrite(3'd6, 1'b1, 32'hFFFF_FFFF);
    bwrite(3'd7, 1'b0, 32'hFFFF_FFFF);
    check("R10 cop after unused writes", 64'(cop_irq), 64'h0000_0000_0002);
    bread(3'd2, 1'b0, rd); check("R10 type untouched", 64'(rd), 64'h1234_5678);
    bread(3'd4, 1'b0, rd); check("R10 block untouched", 64'(rd), 64'h0);
    bread(3'd5, 1'b0, rd); check("R10 unused reads zero", 64'(rd), 64'h0);
    bwrite(3'd0, 1'b1, 32'hFFFF_FFFF);
    bread(3'd0, 1'b1, rd); check("R10 upper bits absent", 64'(rd), 64'h0000_FFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule